// File: doc/BRIEF.md
# Dual-Bank Port Register File

This block keeps the state of an eight-line open-drain port in two full register banks, a normal bank and a suspend bank. Each bank holds a line register that releases or pulls low each line, a rising-edge interrupt mask and a falling-edge interrupt mask. An active-low suspend input chooses which bank drives the line controls and the active masks. A board can therefore load both states ahead of time and move the whole port between them by toggling one pin, with no bus transaction.

The block sits behind a serial-bus slave. The slave presents a small register bus: an address, a write strobe with data, a combinational read port, a software-reset pulse and a capture strobe. The capture strobe latches the actual pin levels into a read-only snapshot register. The slave fires this strobe at the end of the acknowledge of the third byte of a read-byte transfer, or of the first byte of a receive-byte transfer. A write aimed at the snapshot address is redirected into the normal line register. A build parameter sets the line registers to come out of reset released (high impedance) or pulled low.

Top module: `dbank_port_regs`

## Requirements
- R1: After reset both line registers hold the value chosen by OUT_RST_HIZ for every bit: all ones (released) when 1, all zeros (pulled low) when 0. Every mask bit in both banks is 1, and the snapshot register is 0.
- R2: A write with wr_en high stores wr_data at the next clock edge into the addressed register. The addresses are 0 normal line, 1 normal rise mask, 2 normal fall mask, 3 suspend line, 4 suspend rise mask and 5 suspend fall mask. Reading that address then returns the stored value.
- R3: While the synchronized suspend_n is 1, line_hiz, rise_mask and fall_mask show the normal bank. While it is 0, they show the suspend bank. A line_hiz bit of 1 releases the line and a bit of 0 pulls it low. A mask bit of 1 masks the interrupt and a bit of 0 enables it.
- R4: suspend_n passes through two flops. A new level sampled at one clock edge changes the outputs after the second edge that follows, and not after the first.
- R5: At a clock edge with latch_strobe high, pin_level is captured into the snapshot register, which reads at address 6. Without a strobe the snapshot holds, whatever pin_level does.
- R6: A write to address 6 stores wr_data into the normal line register (address 0) and leaves the snapshot unchanged.
- R7: A soft_rst pulse returns every register to its R1 value at the next edge. It takes priority over a write in the same cycle.
- R8: Address 7 reads as 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register address for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data of reg_addr |
| soft_rst | input | 1 | Software reset pulse from the bus slave |
| latch_strobe | input | 1 | Capture strobe for the pin snapshot |
| suspend_n | input | 1 | Bank select, 1 normal, 0 suspend (asynchronous) |
| pin_level | input | 8 | Actual logic levels of the lines |
| line_hiz | output | 8 | Per line: 1 release, 0 pull low |
| rise_mask | output | 8 | Active rising-edge masks, 1 masked |
| fall_mask | output | 8 | Active falling-edge masks, 1 masked |

## Verification
Suppose a bank register holds the wrong value. It shows at rd_data as soon as its address is read. It shows on line_hiz or the masks whenever its bank is live, within two clocks of the bank becoming live. A synchronizer that is too short or too long moves the output change by one edge from the second edge after the sampled change. A wrong write decode shows at once as a changed value at a neighbouring address or at the snapshot. A snapshot that captures without a strobe shows as a changed read value at address 6.

// File: rtl/dbank_pkg.sv
// Package: shared address map and sizes of the dual-bank port register file.
// Assumes: one address space of eight entries; the bank registers sit at the bottom.
package dbank_pkg;
    localparam int ADDR_W        = 3;
    localparam int REGS_PER_BANK = 3;
    localparam int NUM_BANKS     = 2;
    localparam int NUM_BANK_REGS = REGS_PER_BANK * NUM_BANKS;

    typedef enum logic [ADDR_W-1:0] {
        AD_N_LINE = 3'd0,
        AD_N_RISE = 3'd1,
        AD_N_FALL = 3'd2,
        AD_S_LINE = 3'd3,
        AD_S_RISE = 3'd4,
        AD_S_FALL = 3'd5,
        AD_PINS   = 3'd6,
        AD_VOID   = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/dbank_sync.sv
// Module: two-flop synchronizer for one asynchronous level.
// Assumes: the input is a slow level; RST_VAL is the output value held in reset.
module dbank_sync #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic stage1;

    // Shift the level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= RST_VAL;
            sync_out <= RST_VAL;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/dbank_set.sv
// Module: one register bank made of a line register, a rise mask and a fall mask.
// Assumes: a write enable per register; clear is a synchronous return to the reset value.
module dbank_set #(
    parameter int   LINES       = 8,
    parameter logic OUT_RST_HIZ = 1'b1
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 clear,
    input  logic [dbank_pkg::REGS_PER_BANK-1:0]  we,
    input  logic [LINES-1:0]                     wdata,
    output logic [LINES-1:0]                     q [dbank_pkg::REGS_PER_BANK]
);
    localparam logic [LINES-1:0] LINE_RST = {LINES{OUT_RST_HIZ}};
    localparam logic [LINES-1:0] MASK_RST = {LINES{1'b1}};

    for (genvar r = 0; r < dbank_pkg::REGS_PER_BANK; r++) begin : g_reg
        localparam logic [LINES-1:0] RST_V = (r == 0) ? LINE_RST : MASK_RST;

        // Hold one register; clear wins over a write.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                q[r] <= RST_V;
            end else if (we[r]) begin
                q[r] <= wdata;
            end
        end
    end
endmodule

// File: rtl/dbank_pinlatch.sv
// Module: snapshot register of the actual pin levels, captured on a strobe.
// Assumes: pin_level is already synchronous or stable around the strobe.
module dbank_pinlatch #(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             strobe,
    input  logic [LINES-1:0] pins,
    output logic [LINES-1:0] snap
);
    // Capture the pins on the strobe; hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            snap <= '0;
        end else if (strobe) begin
            snap <= pins;
        end
    end
endmodule

// File: rtl/dbank_port_regs.sv
// Module: dual-bank port register file; the synchronized suspend_n picks the live bank.
// Assumes: the bus slave gives one-cycle wr_en, soft_rst and latch_strobe pulses.
//          Reads are combinational on reg_addr.
module dbank_port_regs #(
    parameter int   LINES       = 8,
    parameter logic OUT_RST_HIZ = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [dbank_pkg::ADDR_W-1:0] reg_addr,
    input  logic                         wr_en,
    input  logic [LINES-1:0]             wr_data,
    output logic [LINES-1:0]             rd_data,
    input  logic                         soft_rst,
    input  logic                         latch_strobe,
    input  logic                         suspend_n,
    input  logic [LINES-1:0]             pin_level,
    output logic [LINES-1:0]             line_hiz,
    output logic [LINES-1:0]             rise_mask,
    output logic [LINES-1:0]             fall_mask
);
    import dbank_pkg::*;

    localparam int NREG = NUM_BANK_REGS;

    logic [NREG-1:0]      we_vec;
    logic [LINES-1:0]     bank_q [NREG];
    logic [LINES-1:0]     snap_q;
    logic                 sel_normal;
    logic [NREG*LINES-1:0] regs_flat;
    reg_addr_e            addr_e;

    assign addr_e = reg_addr_e'(reg_addr);

    // Decode writes; the snapshot address is steered to the normal line register.
    always_comb begin
        we_vec = '0;
        if (wr_en) begin
            if (addr_e == AD_PINS) begin
                we_vec[AD_N_LINE] = 1'b1;
            end else if (int'(reg_addr) < NREG) begin
                we_vec[reg_addr] = 1'b1;
            end
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [LINES-1:0] set_q [REGS_PER_BANK];

        dbank_set #(.LINES(LINES), .OUT_RST_HIZ(OUT_RST_HIZ)) u_set (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (soft_rst),
            .we    (we_vec[b*REGS_PER_BANK +: REGS_PER_BANK]),
            .wdata (wr_data),
            .q     (set_q)
        );

        for (genvar r = 0; r < REGS_PER_BANK; r++) begin : g_map
            assign bank_q[b*REGS_PER_BANK + r] = set_q[r];
            assign regs_flat[(b*REGS_PER_BANK + r)*LINES +: LINES] = set_q[r];
        end
    end

    dbank_pinlatch #(.LINES(LINES)) u_pins (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (soft_rst),
        .strobe (latch_strobe),
        .pins   (pin_level),
        .snap   (snap_q)
    );

    dbank_sync #(.RST_VAL(1'b1)) u_susp (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (suspend_n),
        .sync_out (sel_normal)
    );

    // Route the live bank to the line controls and the active masks.
    always_comb begin
        if (sel_normal) begin
            line_hiz  = bank_q[AD_N_LINE];
            rise_mask = bank_q[AD_N_RISE];
            fall_mask = bank_q[AD_N_FALL];
        end else begin
            line_hiz  = bank_q[AD_S_LINE];
            rise_mask = bank_q[AD_S_RISE];
            fall_mask = bank_q[AD_S_FALL];
        end
    end

    // Read multiplexer: bank registers, the snapshot, then zero.
    always_comb begin
        if (addr_e == AD_PINS) begin
            rd_data = snap_q;
        end else if (int'(reg_addr) < NREG) begin
            rd_data = bank_q[reg_addr];
        end else begin
            rd_data = '0;
        end
    end
endmodule

// File: rtl/dbank_port_regs_chk.sv
// Module: assertion checker for dbank_port_regs, attached by bind.
// Assumes: it sees the top ports plus the register contents and the snapshot.
module dbank_port_regs_chk #(
    parameter int   LINES       = 8,
    parameter logic OUT_RST_HIZ = 1'b1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [2:0]             reg_addr,
    input logic                   wr_en,
    input logic [LINES-1:0]       wr_data,
    input logic                   soft_rst,
    input logic                   latch_strobe,
    input logic                   suspend_n,
    input logic [LINES-1:0]       pin_level,
    input logic [LINES-1:0]       line_hiz,
    input logic [LINES-1:0]       rise_mask,
    input logic [LINES-1:0]       fall_mask,
    input logic [6*LINES-1:0]     regs_flat,
    input logic [LINES-1:0]       snap_q
);
    logic [1:0] cyc;

    // Count edges out of reset, saturating, so that old samples are trusted.
    always_ff @(posedge clk) begin
        if (!rst_n) cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    // R3 R4
    bank_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2) |-> (line_hiz == ($past(suspend_n, 2) ? regs_flat[0 +: LINES]
                                                            : regs_flat[3*LINES +: LINES])));

    // R3
    mask_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2) |-> (rise_mask == ($past(suspend_n, 2) ? regs_flat[LINES +: LINES]
                                                             : regs_flat[4*LINES +: LINES])));

    // R5
    snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_strobe && !soft_rst) |=> (snap_q == $past(pin_level)));

    // R5
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_strobe && !soft_rst) |=> $stable(snap_q));

    // R6
    redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == 3'd6 && !soft_rst) |=> (regs_flat[0 +: LINES] == $past(wr_data)));

    // R7
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (regs_flat[0 +: LINES] == {LINES{OUT_RST_HIZ}} &&
                      regs_flat[LINES +: LINES] == {LINES{1'b1}} && snap_q == '0));

    // R8
    void_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == 3'd7 && !soft_rst) |=> $stable(regs_flat));

    // R3
    fall_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2) |-> (fall_mask == ($past(suspend_n, 2) ? regs_flat[2*LINES +: LINES]
                                                             : regs_flat[5*LINES +: LINES])));
endmodule

bind dbank_port_regs dbank_port_regs_chk #(.LINES(LINES), .OUT_RST_HIZ(OUT_RST_HIZ)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (reg_addr),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .soft_rst     (soft_rst),
    .latch_strobe (latch_strobe),
    .suspend_n    (suspend_n),
    .pin_level    (pin_level),
    .line_hiz     (line_hiz),
    .rise_mask    (rise_mask),
    .fall_mask    (fall_mask),
    .regs_flat    (regs_flat),
    .snap_q       (snap_q)
);

// File: tb/dbank_port_regs_test.sv
// Bench: sweeps the register map, bank switching, snapshot, redirect and soft reset.
// Assumes: inputs are driven at the falling edge and outputs are checked in the low phase.
module dbank_port_regs_test;
    localparam int   LINES  = 8;
    localparam logic HIZ    = 1'b1;
    localparam logic [7:0] LRST = {8{HIZ}};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       soft_rst = 1'b0;
    logic       latch_strobe = 1'b0;
    logic       suspend_n = 1'b1;
    logic [7:0] pin_level = '0;
    logic [7:0] line_hiz, rise_mask, fall_mask;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model [7];
    bit done = 0;

    dbank_port_regs #(.LINES(LINES), .OUT_RST_HIZ(HIZ)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .soft_rst(soft_rst),
        .latch_strobe(latch_strobe), .suspend_n(suspend_n), .pin_level(pin_level),
        .line_hiz(line_hiz), .rise_mask(rise_mask), .fall_mask(fall_mask)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; wr_data = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic reset_model();
        model[0] = LRST; model[1] = 8'hFF; model[2] = 8'hFF;
        model[3] = LRST; model[4] = 8'hFF; model[5] = 8'hFF;
        model[6] = 8'h00;
    endtask

    task automatic all_chk(input string tag);
        for (int a = 0; a < 7; a++) rd_chk(tag, 3'(a), model[a]);
        rd_chk({tag, " R8 void"}, 3'd7, 8'h00);
    endtask

    task automatic out_chk(input string tag, input bit normal);
        int base;
        base = normal ? 0 : 3;
        chk({tag, " line"}, line_hiz, model[base]);
        chk({tag, " rise"}, rise_mask, model[base+1]);
        chk({tag, " fall"}, fall_mask, model[base+2]);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        reset_model();
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        all_chk("R1 reset");
        out_chk("R1 reset outputs", 1);

        // R2 sweep every bank register with arithmetic patterns
        for (int a = 0; a < 6; a++) begin
            for (int k = 0; k < 10; k++) begin
                logic [7:0] d;
                d = (k < 8) ? (8'(1 << k) ^ 8'(a * 17)) : 8'(a * 53 + k * 29 + 7);
                wr(3'(a), d);
                model[a] = d;
                rd_chk("R2 write/read", 3'(a), d);
            end
        end
        all_chk("R2 neighbours");

        // R3 R4 bank switching with several loaded patterns
        for (int p = 0; p < 4; p++) begin
            for (int a = 0; a < 6; a++) begin
                wr(3'(a), 8'(p * 61 + a * 23 + 5));
                model[a] = 8'(p * 61 + a * 23 + 5);
            end
            tick(); tick();
            out_chk("R3 normal bank", 1);
            suspend_n = 1'b0;
            tick();
            out_chk("R4 one edge still normal", 1);
            tick();
            out_chk("R4 R3 suspend bank after two edges", 0);
            suspend_n = 1'b1;
            tick();
            out_chk("R4 one edge still suspend", 0);
            tick();
            out_chk("R4 R3 normal bank again", 1);
        end

        // R5 snapshot capture and hold
        for (int v = 0; v < 16; v++) begin
            pin_level = 8'(v * 37 + 3);
            latch_strobe = 1'b1;
            tick();
            latch_strobe = 1'b0;
            model[6] = 8'(v * 37 + 3);
            rd_chk("R5 capture", 3'd6, model[6]);
            pin_level = ~pin_level;
            tick();
            rd_chk("R5 hold without strobe", 3'd6, model[6]);
        end

        // R6 redirect of snapshot writes
        for (int k = 0; k < 4; k++) begin
            wr(3'd6, 8'(k * 71 + 9));
            model[0] = 8'(k * 71 + 9);
            rd_chk("R6 redirect to normal line", 3'd0, model[0]);
            rd_chk("R6 snapshot untouched", 3'd6, model[6]);
            chk("R6 live line", line_hiz, model[0]);
        end

        // R8 void address
        wr(3'd7, 8'h5A);
        all_chk("R8 after void write");

        // R7 soft reset beats a same-cycle write
        reg_addr = 3'd1; wr_data = 8'h00; wr_en = 1'b1; soft_rst = 1'b1;
        tick();
        wr_en = 1'b0; soft_rst = 1'b0;
        reset_model();
        all_chk("R7 soft reset");
        suspend_n = 1'b0;
        tick(); tick();
        out_chk("R7 suspend bank reset", 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule